// File: doc/BRIEF.md
# CMAC Block Chaining Controller

This block runs the chaining loop of a cipher-based message authentication code. Software or an upstream unit delivers the message already padded, as a stream of blocks that are each one cipher block wide. Every block comes with a flag that marks the final block and a flag that says whether padding was added to it. The controller keeps a running chaining value and combines each block with it. Before the final block is combined, the controller XORs it with one of two subkeys. The result goes to an external block cipher over a valid/ready request channel. The cipher's answer comes back on a response strobe and becomes the next chaining value.

When the cipher returns the result for the final block, the controller presents the top bits of that result as the tag, with a one-cycle valid pulse. The tag width is fixed for every message under one key. The two subkeys and their valid flag come from a separate derivation unit. A key-change strobe abandons any message in progress.

Top module: `cmac_chain_ctrl`

## Requirements
- R1: After reset, `cipherReqValid` and `tagValid` are low and `tagData` is all zeros.
- R2: `blkReady` stays low while `subkeyValid` is low, and no block is accepted then.
- R3: The chaining value is zero at the start of every message. For a block that is not final, the cipher request equals the chaining value XOR the block, and `blkPadded` has no effect on it.
- R4: A final block with `blkPadded`=0 is also XORed with `subkey1` before it goes into the request.
- R5: A final block with `blkPadded`=1 is also XORed with `subkey2` before it goes into the request.
- R6: The cycle after the cipher response for a final block, `tagValid` is high for exactly one cycle. `tagData` then holds the upper TAG_W bits (bits BLK_W-1 down to BLK_W-TAG_W) of that response.
- R7: A message of N blocks causes exactly N cipher requests.
- R8: `blkReady` is low from the cycle after a block is accepted until the cipher response for that block arrives.
- R9: While `cipherReqValid` is high and `cipherReqReady` is low, the request stays asserted and `cipherReqData` stays unchanged.
- R10: A one-cycle `keyChange` pulse drops the current message. No tag is produced for it, and the next message starts again from a zero chaining value.
- R11: A cipher response that arrives when no request is outstanding is ignored. It produces no tag and leaves the chaining value unchanged.
- R12: Messages that follow each other are independent. Each tag depends only on the blocks of its own message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyChange | input | 1 | Key replaced; aborts the current message |
| subkeyValid | input | 1 | Both subkeys are valid |
| subkey1 | input | BLK_W | Mask for a complete final block |
| subkey2 | input | BLK_W | Mask for a padded final block |
| blkValid | input | 1 | Input block present |
| blkReady | output | 1 | Controller accepts a block this cycle |
| blkData | input | BLK_W | Message block, already padded |
| blkLast | input | 1 | Block is the final one of the message |
| blkPadded | input | 1 | Final block was padded |
| cipherReqValid | output | 1 | Request to the cipher present |
| cipherReqReady | input | 1 | Cipher takes the request |
| cipherReqData | output | BLK_W | Block to encrypt |
| cipherRespValid | input | 1 | Cipher result strobe |
| cipherRespData | input | BLK_W | Cipher result |
| tagValid | output | 1 | One-cycle tag strobe |
| tagData | output | TAG_W | Truncated tag |

## Verification
The cipher is replaced by a keyed mixing function with a fixed latency, and the bench derives every expected request word and tag on its own from that function. Messages of one, two, three and four blocks are sent. Ending on a complete block versus a padded block separates the two subkey paths, and the padded flag is toggled on blocks that are not final to show it has no effect there. A stalled cipher handshake, an abort in the middle of a message and an unsolicited response are each followed by a fresh message. This shows whether leftover chaining state leaks into the next tag.

// File: rtl/cmac_chain_pkg.sv
package cmac_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } chainState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBlk;   // capture masked block into request register
    logic takeResp;  // cipher answer becomes chaining value
    logic finish;    // answer was for the final block: latch tag, zero chain
    logic clear;     // abort: zero chain
  } chainStrobe_t;

endpackage

// File: rtl/cmac_chain_mask.sv
module cmac_chain_mask #(
  parameter int BLK_W = 128
) (
  input  logic             isLast,
  input  logic             isPadded,
  input  logic [BLK_W-1:0] subkey1,
  input  logic [BLK_W-1:0] subkey2,
  output logic [BLK_W-1:0] mask
);

  always_comb begin
    if (!isLast)       mask = '0;
    else if (isPadded) mask = subkey2;
    else               mask = subkey1;
  end

endmodule

// File: rtl/cmac_chain_fsm.sv
module cmac_chain_fsm
  import cmac_chain_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyChange,
  input  logic         subkeyValid,
  input  logic         blkValid,
  input  logic         blkLast,
  output logic         blkReady,
  input  logic         cipherReqReady,
  output logic         cipherReqValid,
  input  logic         cipherRespValid,
  output logic         tagValid,
  output chainStrobe_t strobe
);

  chainState_t state, stateNext;
  logic        lastQ;
  logic        accept;

  assign blkReady       = (state == ST_IDLE) && subkeyValid && !keyChange;
  assign accept         = blkValid && blkReady;
  assign cipherReqValid = (state == ST_ISSUE) && !keyChange;

  always_comb begin
    strobe          = '0;
    strobe.loadBlk  = accept;
    strobe.takeResp = (state == ST_WAIT) && cipherRespValid && !keyChange;
    strobe.finish   = strobe.takeResp && lastQ;
    strobe.clear    = keyChange;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept)          stateNext = ST_ISSUE;
      ST_ISSUE: if (cipherReqReady)  stateNext = ST_WAIT;
      ST_WAIT:  if (cipherRespValid) stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
    if (keyChange) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastQ    <= 1'b0;
      tagValid <= 1'b0;
    end else begin
      state    <= stateNext;
      tagValid <= strobe.finish;
      if (accept) lastQ <= blkLast;
    end
  end

  p_ready_needs_keys_r2: assert property (@(posedge clk) disable iff (!rstN)
    blkReady |-> subkeyValid);

  p_busy_blocks_input_r8: assert property (@(posedge clk) disable iff (!rstN)
    cipherReqValid |-> !blkReady);

  p_single_tag_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    tagValid |=> !tagValid);

  p_tag_follows_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    tagValid |-> $past(cipherRespValid));

  p_abort_quiets_r10: assert property (@(posedge clk) disable iff (!rstN)
    keyChange |=> (!tagValid && !cipherReqValid));

endmodule

// File: rtl/cmac_chain_dp.sv
module cmac_chain_dp
  import cmac_chain_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int TAG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainStrobe_t     strobe,
  input  logic [BLK_W-1:0] blkData,
  input  logic [BLK_W-1:0] mask,
  input  logic [BLK_W-1:0] respData,
  output logic [BLK_W-1:0] reqData,
  output logic [TAG_W-1:0] tagData
);

  localparam int TAG_LSB = BLK_W - TAG_W;

  logic [BLK_W-1:0] chainQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainQ  <= '0;
      reqData <= '0;
      tagData <= '0;
    end else begin
      if (strobe.loadBlk) reqData <= chainQ ^ blkData ^ mask;
      if (strobe.clear || strobe.finish) chainQ <= '0;
      else if (strobe.takeResp)          chainQ <= respData;
      if (strobe.finish) tagData <= respData[BLK_W-1:TAG_LSB];
    end
  end

endmodule

// File: rtl/cmac_chain_ctrl.sv
module cmac_chain_ctrl
  import cmac_chain_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int TAG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyChange,
  input  logic             subkeyValid,
  input  logic [BLK_W-1:0] subkey1,
  input  logic [BLK_W-1:0] subkey2,
  input  logic             blkValid,
  output logic             blkReady,
  input  logic [BLK_W-1:0] blkData,
  input  logic             blkLast,
  input  logic             blkPadded,
  output logic             cipherReqValid,
  input  logic             cipherReqReady,
  output logic [BLK_W-1:0] cipherReqData,
  input  logic             cipherRespValid,
  input  logic [BLK_W-1:0] cipherRespData,
  output logic             tagValid,
  output logic [TAG_W-1:0] tagData
);

  chainStrobe_t     strobe;
  logic [BLK_W-1:0] mask;

  cmac_chain_fsm u_fsm (
    .clk             (clk),
    .rstN            (rstN),
    .keyChange       (keyChange),
    .subkeyValid     (subkeyValid),
    .blkValid        (blkValid),
    .blkLast         (blkLast),
    .blkReady        (blkReady),
    .cipherReqReady  (cipherReqReady),
    .cipherReqValid  (cipherReqValid),
    .cipherRespValid (cipherRespValid),
    .tagValid        (tagValid),
    .strobe          (strobe)
  );

  cmac_chain_mask #(.BLK_W(BLK_W)) u_mask (
    .isLast   (blkLast),
    .isPadded (blkPadded),
    .subkey1  (subkey1),
    .subkey2  (subkey2),
    .mask     (mask)
  );

  cmac_chain_dp #(.BLK_W(BLK_W), .TAG_W(TAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .blkData  (blkData),
    .mask     (mask),
    .respData (cipherRespData),
    .reqData  (cipherReqData),
    .tagData  (tagData)
  );

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cipherReqValid && !cipherReqReady && !keyChange) |=> (cipherReqValid && $stable(cipherReqData)));

endmodule

// File: tb/cmac_chain_ctrl_bench.sv
module cmac_chain_ctrl_bench;
  localparam int BW = 128;
  localparam int TW = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, keyChange, subkeyValid, blkValid, blkReady, blkLast, blkPadded;
  logic [BW-1:0] subkey1, subkey2, blkData, cipherReqData, cipherRespData;
  logic cipherReqValid, cipherReqReady, cipherRespValid, tagValid;
  logic [TW-1:0] tagData;

  int total = 0;
  int bad = 0;

  cmac_chain_ctrl #(.BLK_W(BW), .TAG_W(TW)) u_cmac_chain_ctrl (
    .clk(clk), .rstN(rstN), .keyChange(keyChange), .subkeyValid(subkeyValid),
    .subkey1(subkey1), .subkey2(subkey2), .blkValid(blkValid), .blkReady(blkReady),
    .blkData(blkData), .blkLast(blkLast), .blkPadded(blkPadded),
    .cipherReqValid(cipherReqValid), .cipherReqReady(cipherReqReady),
    .cipherReqData(cipherReqData), .cipherRespValid(cipherRespValid),
    .cipherRespData(cipherRespData), .tagValid(tagValid), .tagData(tagData));

  function automatic logic [BW-1:0] cipherModel(input logic [BW-1:0] x);
    return {x[BW-8:0], x[BW-1:BW-7]} ^ (x >> 5) ^ 128'h5A3C_96E1_0F87_2D4B_C3A5_1E69_7B0D_F248;
  endfunction

  function automatic logic [BW-1:0] genBlk(input int seed, input int i);
    return {32'(seed) ^ 32'hA5A5_0000, 32'(i) * 32'h9E37_79B9, 32'(seed * 7 + i), ~(32'(seed) ^ 32'(i))};
  endfunction

  // cipher stand-in: fixed latency, one request at a time
  logic mBusy, mRespV, stall, strayV;
  int   mCnt;
  logic [BW-1:0] mData, strayD;
  assign cipherReqReady  = !mBusy && !stall;
  assign cipherRespValid = mRespV | strayV;
  assign cipherRespData  = strayV ? strayD : mData;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mCnt <= 0; mRespV <= 1'b0; mData <= '0;
    end else begin
      mRespV <= 1'b0;
      if (cipherReqValid && cipherReqReady) begin
        mBusy <= 1'b1; mCnt <= 3; mData <= cipherModel(cipherReqData);
      end else if (mBusy) begin
        if (mCnt == 1) begin mBusy <= 1'b0; mRespV <= 1'b1; end
        mCnt <= mCnt - 1;
      end
    end
  end

  // monitor
  int reqCnt = 0;
  int tagCnt = 0;
  int tagLate = 0;
  logic prevResp = 1'b0;
  logic [BW-1:0] reqLog [16];
  logic [TW-1:0] tagSeen = '0;

  always @(posedge clk) begin
    prevResp <= cipherRespValid;
    if (rstN && cipherReqValid && cipherReqReady) begin
      reqLog[reqCnt % 16] <= cipherReqData;
      reqCnt <= reqCnt + 1;
    end
    if (rstN && tagValid) begin
      tagCnt  <= tagCnt + 1;
      tagSeen <= tagData;
      if (!prevResp) tagLate <= tagLate + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushBlk(input logic [BW-1:0] b, input bit last, input bit padded);
    int waitc;
    @(negedge clk);
    blkValid = 1'b1; blkData = b; blkLast = last; blkPadded = padded;
    waitc = 0;
    while (!blkReady && waitc < 200) begin @(negedge clk); waitc++; end
    @(posedge clk); #1;
    blkValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic runMsg(input int n, input int seed, input bit padded, input string label);
    logic [BW-1:0] chain, x, b;
    int reqBase, tagBase, waitc;
    string req;
    reqBase = reqCnt; tagBase = tagCnt; chain = '0;
    for (int i = 0; i < n; i++) begin
      b = genBlk(seed, i);
      pushBlk(b, i == n - 1, (i == n - 1) ? padded : !padded);
      check(blkReady == 1'b0, {"R8 busy ", label}, BW'(blkReady), '0);
      x = chain ^ b ^ ((i == n - 1) ? (padded ? subkey2 : subkey1) : '0);
      waitc = 0;
      while (reqCnt <= reqBase + i && waitc < 50) begin @(negedge clk); waitc++; end
      req = (i != n - 1) ? "R3" : (padded ? "R5" : "R4");
      check(reqLog[(reqBase + i) % 16] == x, {req, " request ", label}, reqLog[(reqBase + i) % 16], x);
      chain = cipherModel(x);
    end
    waitc = 0;
    while (tagCnt == tagBase && waitc < 50) begin @(negedge clk); waitc++; end
    repeat (4) @(negedge clk);
    check(tagCnt == tagBase + 1, {"R6 pulse count ", label}, BW'(tagCnt - tagBase), BW'(1));
    check(tagSeen == chain[BW-1 -: TW], {"R6 tag value ", label}, BW'(tagSeen), BW'(chain[BW-1 -: TW]));
    check(reqCnt == reqBase + n, {"R7 request count ", label}, BW'(reqCnt - reqBase), BW'(n));
  endtask

  task automatic testReset();
    check(cipherReqValid == 1'b0, "R1 reqValid", BW'(cipherReqValid), '0);
    check(tagValid == 1'b0, "R1 tagValid", BW'(tagValid), '0);
    check(tagData == '0, "R1 tagData", BW'(tagData), '0);
  endtask

  task automatic testNoKeys();
    int base;
    base = reqCnt;
    @(negedge clk);
    subkeyValid = 1'b0;
    blkValid = 1'b1; blkData = genBlk(99, 0); blkLast = 1'b1; blkPadded = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check(blkReady == 1'b0, "R2 ready without keys", BW'(blkReady), '0);
    end
    blkValid = 1'b0;
    @(negedge clk);
    subkeyValid = 1'b1;
    repeat (6) @(negedge clk);
    check(reqCnt == base, "R2 nothing accepted", BW'(reqCnt - base), '0);
  endtask

  task automatic testStall();
    logic [BW-1:0] x, b;
    int tagBase, waitc;
    tagBase = tagCnt;
    b = genBlk(41, 0);
    @(negedge clk); stall = 1'b1;
    pushBlk(b, 1'b1, 1'b1);
    x = b ^ subkey2;
    repeat (4) begin
      check(cipherReqValid == 1'b1, "R9 request held", BW'(cipherReqValid), BW'(1));
      check(cipherReqData == x, "R9 data stable", cipherReqData, x);
      @(negedge clk);
    end
    stall = 1'b0;
    waitc = 0;
    while (tagCnt == tagBase && waitc < 50) begin @(negedge clk); waitc++; end
    @(negedge clk);
    check(tagSeen == cipherModel(x) >> (BW - TW), "R9 tag after stall", BW'(tagSeen), cipherModel(x) >> (BW - TW));
  endtask

  task automatic testAbort();
    int tagBase;
    tagBase = tagCnt;
    pushBlk(genBlk(55, 0), 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    pushBlk(genBlk(55, 1), 1'b0, 1'b0);
    @(negedge clk);
    keyChange = 1'b1;
    @(negedge clk);
    keyChange = 1'b0;
    repeat (12) @(negedge clk);
    check(tagCnt == tagBase, "R10 no tag after abort", BW'(tagCnt - tagBase), '0);
    runMsg(1, 56, 1'b0, "R10 fresh after abort");
  endtask

  task automatic testStray();
    int tagBase;
    tagBase = tagCnt;
    @(negedge clk);
    strayV = 1'b1; strayD = genBlk(77, 3);
    @(negedge clk);
    strayV = 1'b0;
    repeat (5) @(negedge clk);
    check(tagCnt == tagBase, "R11 stray ignored", BW'(tagCnt - tagBase), '0);
    runMsg(2, 78, 1'b1, "R11 after stray");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; keyChange = 1'b0; subkeyValid = 1'b1; blkValid = 1'b0;
    blkData = '0; blkLast = 1'b0; blkPadded = 1'b0; stall = 1'b0;
    strayV = 1'b0; strayD = '0;
    subkey1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    subkey2 = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runMsg(1, 1, 1'b0, "one block complete");
    runMsg(1, 2, 1'b1, "one block padded");
    runMsg(3, 3, 1'b0, "three blocks complete");
    runMsg(4, 4, 1'b1, "R12 four blocks padded");
    runMsg(2, 5, 1'b0, "R12 back to back");
    testNoKeys();
    testStall();
    testAbort();
    testStray();
    check(tagLate == 0, "R6 tag one cycle after response", BW'(tagLate), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule